// File: doc/BRIEF.md
# Reservation Tracker for Load-Reserved / Store-Conditional

This unit holds the single address reservation that pairs a load-reserved access with a later store-conditional access. The execute stage hands it one decoded request per cycle. Each request carries a kind (load-reserved or store-conditional), an access size, the address before translation and, for a store-conditional, the data register value. In the same cycle the memory stage reports whether translation or the memory access faulted.

The unit decides four things for each request. It checks whether the access is misaligned. For a store-conditional, it decides whether the store may go to memory and what status value goes back to the destination register. It also decides whether the reservation is set, kept or dropped. Trap entry and the two privilege-return events each drop the reservation through their own pulse inputs. The reservation is visible at the ports so that the surrounding pipeline and the bench can observe it.

Top module: `lrsc_resv_unit`

## Requirements
- R1: `misaligned` is high while `req_valid` is high and the address fails the check for `req_size`. Size code 00 (byte) is always aligned. Code 01 (half) needs bit 0 clear, code 10 (word) needs bits 1:0 clear, and code 11 (double) needs bits 2:0 clear.
- R2: A misaligned request drives `store_en` and `rd_we` low and leaves `resv_valid` and `resv_addr` unchanged.
- R3: An aligned load-reserved with `mem_fault` low sets `resv_valid` to 1 and `resv_addr` to the request address from the next cycle on.
- R4: An aligned load-reserved with `mem_fault` high leaves the reservation unchanged.
- R5: An aligned store-conditional whose full address differs from `resv_addr`, or that arrives while `resv_valid` is 0, keeps `store_en` low. It raises `rd_we` with `rd_data` equal to 1, zero-extended, and leaves the reservation unchanged.
- R6: An aligned store-conditional whose address matches a valid reservation raises `store_en`. If `mem_fault` is low it also raises `rd_we` with `rd_data` equal to 0, and `resv_valid` is 0 from the next cycle.
- R7: A matching store-conditional with `mem_fault` high keeps `rd_we` low and keeps the reservation.
- R8: `store_data` is `req_wdata` for size code 11. For size code 10 it carries the low 32 bits of `req_wdata` with all upper bits zero.
- R9: A pulse on `trap_enter`, `mret` or `sret` clears `resv_valid` from the next cycle.
- R10: When a load-reserved sets the reservation in the same cycle as a cancel pulse, the set wins.
- R11: After reset `resv_valid` is 0, and with no request `store_en`, `rd_we` and `misaligned` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_sc | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_size | input | 2 | Access size code: 00 byte, 01 half, 10 word, 11 double |
| req_addr | input | XLEN | Address before translation |
| req_wdata | input | XLEN | Data register value for a store-conditional |
| mem_fault | input | 1 | Translation or memory access faulted for this request |
| trap_enter | input | 1 | Trap entry pulse |
| mret | input | 1 | Machine-mode return pulse |
| sret | input | 1 | Supervisor-mode return pulse |
| misaligned | output | 1 | Raise the store/AMO address-misaligned exception |
| store_en | output | 1 | Memory stage performs the conditional store |
| store_data | output | XLEN | Data to store, narrowed for word size |
| rd_we | output | 1 | Write the status value to the destination register |
| rd_data | output | XLEN | Status value: 0 on success, 1 on failure |
| resv_valid | output | 1 | A reservation is held |
| resv_addr | output | XLEN | Reserved address |

## Verification
A cancel pulse can fall in the same cycle as a request that sets or clears the reservation. The stimulus table drives a trap pulse alongside a load-reserved, a machine return alongside a successful store-conditional, and a supervisor return alongside another load-reserved. The bench judges each case by reading `resv_valid` and `resv_addr` one edge later. The set must survive the cancel pulse, and a clear followed by a cancel must still leave the reservation empty.

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_sc,
  input  logic [1:0]      req_size,
  input  logic [XLEN-1:0] req_addr,
  input  logic [XLEN-1:0] req_wdata,
  input  logic            mem_fault,
  input  logic            trap_enter,
  input  logic            mret,
  input  logic            sret,
  output logic            misaligned,
  output logic            store_en,
  output logic [XLEN-1:0] store_data,
  output logic            rd_we,
  output logic [XLEN-1:0] rd_data,
  output logic            resv_valid,
  output logic [XLEN-1:0] resv_addr
);

  logic aligned;
  always_comb begin
    unique case (req_size)
      2'b00:   aligned = 1'b1;
      2'b01:   aligned = ~req_addr[0];
      2'b10:   aligned = req_addr[1:0] == 2'b00;
      default: aligned = req_addr[2:0] == 3'b000;
    endcase
  end

  wire hit    = resv_valid && (resv_addr == req_addr);
  wire sc_go  = req_valid && req_sc && aligned;
  wire lr_set = req_valid && !req_sc && aligned && !mem_fault;
  wire sc_ok  = sc_go && hit && !mem_fault;
  wire cancel = trap_enter || mret || sret;

  assign misaligned = req_valid && !aligned;
  assign store_en   = sc_go && hit;
  assign rd_we      = sc_go && (!hit || !mem_fault);
  assign rd_data    = {{(XLEN-1){1'b0}}, ~hit};

  always_comb begin
    store_data = req_wdata;
    if (req_size == 2'b10)
      for (int i = 32; i < XLEN; i++) store_data[i] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else if (lr_set) begin
      resv_valid <= 1'b1;
      resv_addr  <= req_addr;
    end else if (cancel || sc_ok) begin
      resv_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lrsc_resv_unit_chk.sv
module lrsc_resv_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_sc,
  input logic [1:0]      req_size,
  input logic [XLEN-1:0] req_addr,
  input logic            mem_fault,
  input logic            trap_enter,
  input logic            mret,
  input logic            sret,
  input logic            misaligned,
  input logic            store_en,
  input logic [XLEN-1:0] store_data,
  input logic            rd_we,
  input logic [XLEN-1:0] rd_data,
  input logic            resv_valid,
  input logic [XLEN-1:0] resv_addr
);

  p_misalign_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (!store_en && !rd_we));

  p_misalign_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (misaligned && !trap_enter && !mret && !sret) |=> ($stable(resv_valid) && $stable(resv_addr)));

  p_lr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sc && !misaligned && !mem_fault) |=> (resv_valid && resv_addr == $past(req_addr)));

  p_sc_fail_nostore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we && rd_data[0]) |-> !store_en);

  p_sc_ok_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !mem_fault) |=> !resv_valid);

  p_sc_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && mem_fault) |-> !rd_we);

  p_word_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sc && req_size == 2'b10) |-> ((store_data >> 32) == '0));

  p_cancel_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((trap_enter || mret || sret) && !(req_valid && !req_sc)) |=> !resv_valid);

endmodule

bind lrsc_resv_unit lrsc_resv_unit_chk #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc),
  .req_size(req_size), .req_addr(req_addr), .mem_fault(mem_fault),
  .trap_enter(trap_enter), .mret(mret), .sret(sret),
  .misaligned(misaligned), .store_en(store_en), .store_data(store_data),
  .rd_we(rd_we), .rd_data(rd_data), .resv_valid(resv_valid), .resv_addr(resv_addr)
);

// File: tb/test_lrsc_resv_unit.sv
module test_lrsc_resv_unit;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_sc = 1'b0, mem_fault = 1'b0;
  logic trap_enter = 1'b0, mret = 1'b0, sret = 1'b0;
  logic [1:0] req_size = 2'b00;
  logic [XLEN-1:0] req_addr = '0, req_wdata = '0;
  logic misaligned, store_en, rd_we, resv_valid;
  logic [XLEN-1:0] store_data, rd_data, resv_addr;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lrsc_resv_unit #(.XLEN(XLEN)) i_lrsc_resv_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_fault(mem_fault), .trap_enter(trap_enter), .mret(mret), .sret(sret),
    .misaligned(misaligned), .store_en(store_en), .store_data(store_data),
    .rd_we(rd_we), .rd_data(rd_data), .resv_valid(resv_valid), .resv_addr(resv_addr)
  );

  typedef struct packed {
    logic [2:0]  cxl;    // {trap_enter, mret, sret}
    logic        v;
    logic        sc;
    logic [1:0]  sz;
    logic [15:0] a;
    logic        f;
    logic        e_mis;
    logic        e_st;
    logic        e_we;
    logic        e_rd;
    logic        e_rv;
    logic [15:0] e_ra;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'b000,1'b1,1'b0,2'b10,16'h0100,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0100, 4'd3},  // R3
    '{3'b000,1'b1,1'b1,2'b10,16'h0104,1'b0, 1'b0,1'b0,1'b1,1'b1, 1'b1,16'h0100, 4'd5},  // R5
    '{3'b000,1'b1,1'b1,2'b10,16'h0102,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,16'h0100, 4'd2},  // R2
    '{3'b000,1'b1,1'b1,2'b11,16'h0100,1'b1, 1'b0,1'b1,1'b0,1'b0, 1'b1,16'h0100, 4'd7},  // R7
    '{3'b000,1'b1,1'b1,2'b10,16'h0100,1'b0, 1'b0,1'b1,1'b1,1'b0, 1'b0,16'h0000, 4'd6},  // R6
    '{3'b000,1'b1,1'b1,2'b10,16'h0100,1'b0, 1'b0,1'b0,1'b1,1'b1, 1'b0,16'h0000, 4'd5},  // R5
    '{3'b000,1'b1,1'b0,2'b11,16'h0204,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000, 4'd1},  // R1
    '{3'b000,1'b1,1'b0,2'b11,16'h0208,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0208, 4'd3},  // R3
    '{3'b000,1'b1,1'b0,2'b10,16'h0300,1'b1, 1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0208, 4'd4},  // R4
    '{3'b100,1'b0,1'b0,2'b00,16'h0000,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000, 4'd9},  // R9
    '{3'b000,1'b1,1'b0,2'b00,16'h0011,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0011, 4'd1},  // R1
    '{3'b010,1'b0,1'b0,2'b00,16'h0000,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000, 4'd9},  // R9
    '{3'b000,1'b1,1'b0,2'b01,16'h0013,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000, 4'd1},  // R1
    '{3'b000,1'b1,1'b0,2'b01,16'h0012,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0012, 4'd1},  // R1
    '{3'b001,1'b0,1'b0,2'b00,16'h0000,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000, 4'd9},  // R9
    '{3'b100,1'b1,1'b0,2'b10,16'h0400,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0400, 4'd10}, // R10
    '{3'b010,1'b1,1'b1,2'b10,16'h0400,1'b0, 1'b0,1'b1,1'b1,1'b0, 1'b0,16'h0000, 4'd6},  // R6
    '{3'b001,1'b1,1'b0,2'b10,16'h0500,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0500, 4'd10}, // R10
    '{3'b000,1'b1,1'b1,2'b10,16'h0400,1'b0, 1'b0,1'b0,1'b1,1'b1, 1'b1,16'h0500, 4'd5},  // R5
    '{3'b000,1'b1,1'b0,2'b11,16'h020C,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,16'h0500, 4'd1}   // R1
  };

  task automatic check(input string req, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_sc = 1'b0; mem_fault = 1'b0;
    trap_enter = 1'b0; mret = 1'b0; sret = 1'b0;
  endtask

  task automatic drive(input logic sc, input logic [1:0] sz, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] wd, input logic f);
    req_valid = 1'b1; req_sc = sc; req_size = sz; req_addr = a; req_wdata = wd; mem_fault = f;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R11", "resv_valid", XLEN'(resv_valid), '0);
    check("R11", "store_en", XLEN'(store_en), '0);
    check("R11", "rd_we", XLEN'(rd_we), '0);
    check("R11", "misaligned", XLEN'(misaligned), '0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      @(negedge clk);
      tag = $sformatf("R%0d", VEC[k].rq);
      {trap_enter, mret, sret} = VEC[k].cxl;
      req_valid = VEC[k].v; req_sc = VEC[k].sc; req_size = VEC[k].sz;
      req_addr = XLEN'(VEC[k].a); mem_fault = VEC[k].f; req_wdata = '0;
      #2;
      check(tag, "misaligned", XLEN'(misaligned), XLEN'(VEC[k].e_mis));
      check(tag, "store_en", XLEN'(store_en), XLEN'(VEC[k].e_st));
      check(tag, "rd_we", XLEN'(rd_we), XLEN'(VEC[k].e_we));
      if (VEC[k].e_we) check(tag, "rd_data", rd_data, XLEN'(VEC[k].e_rd));
      @(posedge clk); #1;
      check(tag, "resv_valid", XLEN'(resv_valid), XLEN'(VEC[k].e_rv));
      if (VEC[k].e_rv) check(tag, "resv_addr", resv_addr, XLEN'(VEC[k].a) & '0 | XLEN'(VEC[k].e_ra));
    end

    // R8: word store narrows data, double passes it whole
    @(negedge clk); idle();
    drive(1'b1, 2'b10, 64'h40, 64'hDEAD_BEEF_1234_5678, 1'b0);
    #2;
    check("R8", "store_data word", store_data, 64'h0000_0000_1234_5678);
    req_size = 2'b11;
    #1;
    check("R8", "store_data double", store_data, 64'hDEAD_BEEF_1234_5678);

    // R5: mismatch in upper address bits only fails the store-conditional
    @(negedge clk); idle();
    drive(1'b0, 2'b11, 64'h0000_0001_0000_0100, '0, 1'b0);
    @(posedge clk); #1;
    check("R3", "resv_addr high", resv_addr, 64'h0000_0001_0000_0100);
    @(negedge clk); idle();
    drive(1'b1, 2'b11, 64'h0000_0000_0000_0100, '0, 1'b0);
    #2;
    check("R5", "store_en upper mismatch", XLEN'(store_en), '0);
    check("R5", "rd_data upper mismatch", rd_data, 64'd1);
    @(posedge clk); #1;
    check("R5", "resv kept", XLEN'(resv_valid), 64'd1);

    // R11: reset mid-run drops the reservation
    @(negedge clk); idle(); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R11", "resv_valid after reset", XLEN'(resv_valid), '0);
    @(negedge clk); rst_n = 1'b1;

    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule